// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the modem status register of one serial channel. It watches four active-low modem inputs: carrier detect, ring indicator, data set ready and clear to send. It shows their asserted (inverted) levels in the upper half of an 8-bit read value. The lower half holds four sticky change flags. Each flag records that its line changed since the CPU last read the register, and the read clears them.

The block has a loopback mode for self-test. In that mode the four status bits come from four modem-control outputs instead of the pins. Change detection runs on whichever source is selected, so toggling the control bits in loopback also raises the flags. The pin inputs pass through a synchroniser. Change detection waits until the synchroniser holds valid data after reset, so the levels present at reset never show up as changes. When any flag is set and the interrupt enable is high, the block raises a modem-status interrupt request.

Top module: `modem_status_reg`

## Requirements
- R1: With loopback off, bits 7, 6, 5 and 4 of `rd_data` equal the inverted levels of `dcd_n`, `ri_n`, `dsr_n` and `cts_n` respectively.
- R2: With loopback on, bits 7, 6, 5 and 4 equal `ctl_out2`, `ctl_out1`, `ctl_dtr` and `ctl_rts` respectively, and the pins have no effect.
- R3: Bits 3, 1 and 0 are set when the status value in bit 7, 5 or 4 respectively changes in either direction.
- R4: Bit 2 is set only when the ring status (bit 6) goes from 1 to 0, which is `ri_n` going from 0 to 1. A change from 0 to 1 leaves bit 2 unchanged.
- R5: A cycle with `rd_stb` high returns the flags held before the clear, and bits 3 to 0 read 0 after that edge.
- R6: A change detected at the same edge as a clearing read leaves its flag set.
- R7: A pin change shows in the status bits 2 clock edges later and in the flags 3 edges later. A control-bit change in loopback shows in the status bits in the same cycle and in the flags 1 edge later.
- R8: Change detection works on the selected source, so control-bit toggles in loopback set flags.
- R9: `ms_irq` is high exactly when `ms_int_en` is high and any of bits 3 to 0 is 1.
- R10: After reset, bits 3 to 0 are 0. Input levels held steadily through reset raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | CPU read of this register, one cycle per read |
| rd_data | output | 8 | Status in bits 7:4, change flags in bits 3:0 |
| dcd_n | input | 1 | Carrier detect pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| loop_en | input | 1 | Loopback select |
| ctl_out2 | input | 1 | Control output routed to bit 7 in loopback |
| ctl_out1 | input | 1 | Control output routed to bit 6 in loopback |
| ctl_dtr | input | 1 | Control output routed to bit 5 in loopback |
| ctl_rts | input | 1 | Control output routed to bit 4 in loopback |
| ms_int_en | input | 1 | Modem-status interrupt enable |
| ms_irq | output | 1 | Modem-status interrupt request |

## Verification
A pin change reaches the status bits after two rising edges and the flags after three. The bench drives pins at a falling edge and samples at the falling edge after the second rising edge, where it expects the new status with the flags still clear. It samples again after the third rising edge, where it expects the flags. In loopback the status follows the control bits within the same cycle, so the bench samples just after driving them. It then samples again one edge later for the flags. The read value is sampled while the strobe is high, and the cleared flags are sampled one falling edge later.

// File: rtl/msr_pkg.sv
package msr_pkg;
   localparam int MSR_LINES   = 4;
   localparam int MSR_RING_IX = 2;   // ring line position inside the 4-bit vectors
   typedef logic [MSR_LINES-1:0] msr_vec_t;   // {carrier, ring, set_ready, clear_send}
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
   parameter int W       = 4,
   parameter int STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("msr_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= {W{RST_VAL}};
         else if (s == 0) stg[s] <= d;
         else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel
   import msr_pkg::*;
#(
   parameter bit HAS_LOOPBACK = 1'b1
) (
   input  msr_vec_t pin_sync_n,
   input  msr_vec_t ctl_bits,
   input  logic     loop_en,
   output msr_vec_t eff
);
   if (HAS_LOOPBACK) begin : g_loop
      assign eff = loop_en ? ctl_bits : ~pin_sync_n;
   end else begin : g_pins_only
      logic unused_loop;
      assign unused_loop = loop_en ^ (|ctl_bits);
      assign eff = ~pin_sync_n;
   end
endmodule

// File: rtl/msr_delta_flags.sv
module msr_delta_flags
   import msr_pkg::*;
#(
   parameter int ARM_CYCLES    = 3,
   parameter bit RING_TRAILING = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  msr_vec_t eff,
   input  logic     clr,
   output msr_vec_t flags
);
   localparam int CW = $clog2(ARM_CYCLES + 1) + 1;

   if (ARM_CYCLES < 1) begin : g_bad_arm
      $error("msr_delta_flags: ARM_CYCLES must be at least 1");
   end

   logic [CW-1:0] arm_cnt;
   logic          armed;
   msr_vec_t      prev_q, hit, flag_q;

   assign armed = (arm_cnt == CW'(ARM_CYCLES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arm_cnt <= '0;
      else if (!armed) arm_cnt <= arm_cnt + 1'b1;
   end

   for (genvar i = 0; i < MSR_LINES; i++) begin : g_line
      if (i == MSR_RING_IX && RING_TRAILING) begin : g_trailing
         assign hit[i] = prev_q[i] & ~eff[i];
      end else begin : g_any
         assign hit[i] = prev_q[i] ^ eff[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         flag_q <= '0;
      end else begin
         prev_q <= eff;
         flag_q <= (flag_q & ~{MSR_LINES{clr}}) | (hit & {MSR_LINES{armed}});
      end
   end

   assign flags = flag_q;
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
   import msr_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter bit HAS_LOOPBACK  = 1'b1,
   parameter bit RING_TRAILING = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_stb,
   output logic [7:0] rd_data,
   input  logic       dcd_n,
   input  logic       ri_n,
   input  logic       dsr_n,
   input  logic       cts_n,
   input  logic       loop_en,
   input  logic       ctl_out2,
   input  logic       ctl_out1,
   input  logic       ctl_dtr,
   input  logic       ctl_rts,
   input  logic       ms_int_en,
   output logic       ms_irq
);
   localparam int ARM = SYNC_STAGES + 1;

   if (2*MSR_LINES != 8) begin : g_bad_width
      $error("modem_status_reg: read word must be 8 bits");
   end

   msr_vec_t pin_raw_n, pin_sync_n, ctl_bits, eff, flags;

   assign pin_raw_n = {dcd_n, ri_n, dsr_n, cts_n};
   assign ctl_bits  = {ctl_out2, ctl_out1, ctl_dtr, ctl_rts};

   msr_sync #(.W(MSR_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw_n), .q(pin_sync_n)
   );

   msr_src_sel #(.HAS_LOOPBACK(HAS_LOOPBACK)) u_sel (
      .pin_sync_n(pin_sync_n), .ctl_bits(ctl_bits), .loop_en(loop_en), .eff(eff)
   );

   msr_delta_flags #(.ARM_CYCLES(ARM), .RING_TRAILING(RING_TRAILING)) u_flags (
      .clk(clk), .rst_n(rst_n), .eff(eff), .clr(rd_stb), .flags(flags)
   );

   assign rd_data = {eff, flags};
   assign ms_irq  = ms_int_en & (|flags);
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_stb,
   input logic [7:0] rd_data,
   input logic       loop_en,
   input logic       ctl_out2,
   input logic       ctl_out1,
   input logic       ctl_dtr,
   input logic       ctl_rts,
   input logic       ms_int_en,
   input logic       ms_irq
);
   // R9
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ms_irq |-> ms_int_en);

   // R9
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ms_irq |-> (rd_data[3:0] != 4'h0));

   // R2
   loop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> (rd_data[7:4] == {ctl_out2, ctl_out1, ctl_dtr, ctl_rts}));

   // R5
   flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

   // R4
   ring_trailing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[2]) |-> !$past(rd_data[6]));
endmodule

bind modem_status_reg msr_checker u_msr_checker (
   .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
   .loop_en(loop_en), .ctl_out2(ctl_out2), .ctl_out1(ctl_out1),
   .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts), .ms_int_en(ms_int_en), .ms_irq(ms_irq)
);

// File: tb/tb_modem_status_reg.sv
`timescale 1ns/1ps
module tb_modem_status_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic       dcd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
   logic       loop_en = 1'b0;
   logic       ctl_out2 = 1'b0, ctl_out1 = 1'b0, ctl_dtr = 1'b0, ctl_rts = 1'b0;
   logic       ms_int_en = 1'b0;
   logic       ms_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   modem_status_reg dut (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
      .dcd_n(dcd_n), .ri_n(ri_n), .dsr_n(dsr_n), .cts_n(cts_n),
      .loop_en(loop_en), .ctl_out2(ctl_out2), .ctl_out1(ctl_out1),
      .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts), .ms_int_en(ms_int_en), .ms_irq(ms_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   // p = {dcd_n, ri_n, dsr_n, cts_n}
   task automatic set_pins(input logic [3:0] p);
      {dcd_n, ri_n, dsr_n, cts_n} = p;
   endtask

   task automatic set_ctl(input logic [3:0] c);
      {ctl_out2, ctl_out1, ctl_dtr, ctl_rts} = c;
   endtask

   // advance n rising edges, return at falling edge
   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   // read: returns value during strobe and value after the clearing edge
   task automatic do_read(output logic [7:0] during, output logic [7:0] after);
      rd_stb = 1'b1;
      #1 during = rd_data;
      @(negedge clk);
      rd_stb = 1'b0;
      #1 after = rd_data;
   endtask

   function automatic logic [3:0] delta(input logic [3:0] a, input logic [3:0] b);
      // a,b are asserted-level status {carrier, ring, set_ready, clear_send}
      return {a[3] ^ b[3], a[2] & ~b[2], a[1] ^ b[1], a[0] ^ b[0]};
   endfunction

   initial begin
      logic [7:0] dr, af;
      // R10: carrier asserted through reset must not raise a flag
      set_pins(4'b0111);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      edges(6);
      chk("R10 reset state", rd_data, 8'h80);
      chk("R9 irq idle", {7'd0, ms_irq}, 8'h00);

      // R1 R3 R4 R5 R7: all pin transitions
      for (int f = 0; f < 16; f++) begin
         for (int t = 0; t < 16; t++) begin
            set_pins(f[3:0]);
            edges(4);
            do_read(dr, af);
            set_pins(t[3:0]);
            edges(2);
            chk("R1 R7 status after 2 edges", rd_data, {~t[3:0], 4'h0});
            edges(1);
            chk("R3 R4 R7 flags after 3 edges", rd_data,
                {~t[3:0], delta(~f[3:0], ~t[3:0])});
            do_read(dr, af);
            chk("R5 read returns flags", dr, {~t[3:0], delta(~f[3:0], ~t[3:0])});
            chk("R5 flags cleared", af, {~t[3:0], 4'h0});
         end
      end

      // R9 interrupt
      set_pins(4'b1111);
      edges(4);
      do_read(dr, af);
      set_pins(4'b1110);
      edges(3);
      chk("R9 irq off when disabled", {7'd0, ms_irq}, 8'h00);
      ms_int_en = 1'b1;
      #1 chk("R9 irq on", {7'd0, ms_irq}, 8'h01);
      do_read(dr, af);
      chk("R9 irq drops after read", {7'd0, ms_irq}, 8'h00);
      ms_int_en = 1'b0;

      // R2 R8 R7: loopback over all control transitions, pins held asserted
      set_pins(4'b0000);
      loop_en = 1'b1;
      edges(5);
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            set_ctl(a[3:0]);
            edges(1);
            do_read(dr, af);
            set_ctl(b[3:0]);
            #1 chk("R2 R7 loop status same cycle", rd_data, {b[3:0], 4'h0});
            edges(1);
            chk("R8 R4 loop flags after 1 edge", rd_data,
                {b[3:0], delta(a[3:0], b[3:0])});
         end
      end

      // R6: change at the clearing edge keeps the flag
      set_ctl(4'b0000);
      edges(1);
      do_read(dr, af);
      set_ctl(4'b0001);
      edges(1);
      chk("R6 precondition", rd_data, 8'h11);
      rd_stb = 1'b1;
      set_ctl(4'b0000);
      #1 chk("R6 read value before clear", rd_data, 8'h01);
      @(negedge clk);
      rd_stb = 1'b0;
      #1 chk("R6 flag survives clear", rd_data, 8'h01);

      // R2: pins have no effect in loopback
      set_pins(4'b1111);
      edges(4);
      chk("R2 pins ignored in loopback", rd_data, 8'h01);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
      end
      #2;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule